// File: doc/BRIEF.md
# Interfield Transfer Cycle Sequencer

This block schedules the memory transfers of a three-port field store used for interfield processing and flicker reduction. Two ports (one read, one write) run at the base pixel rate. A second read port runs at twice that rate. The sequencer repeats a main cycle made of four equal slots. In each slot it first shifts a group address out serially, under a strobe, and then raises a one-cycle transfer command. A transfer-kind code goes with that command. The slot pattern serves the fast read port twice per main cycle. The other two ports are served once each, so every port receives a fresh group at the rate its own 16-word blocks use up.

The sequencer keeps one group counter per port. A counter advances after each transfer of its port and wraps at a power-of-two field size. A start pulse aligns the schedule to a field boundary and clears all three counters. The slot length, the address width and the bit order of the serial address are parameters. An elaboration-time check rejects any address width that does not leave room for the transfer command inside one slot.

Top module: `ifx_transfer_seq`

## Requirements
- R1: After reset, and until the first start pulse, addr_stb and xfer_stb stay low and slot_idx reads 0.
- R2: After a start pulse, the slots follow the repeating order slot_idx 0,1,2,3. The kind codes are 0 (read fast port) for slots 0 and 2, 1 (read slow port) for slot 1, and 2 (write port) for slot 3. xfer_kind always shows the kind of the current slot.
- R3: In each slot of SLOT_CYC cycles, addr_stb is high exactly during the first GRP_W cycles. addr_bit carries the group address of the slot's port, most significant bit first when MSB_FIRST is 1.
- R4: xfer_stb is high for exactly one cycle per slot, in the slot's last cycle, and never together with addr_stb.
- R5: The group address of a port rises by one after each transfer of that port. The fast read port therefore gets two consecutive addresses per main cycle. Ports that are not transferred in a slot keep their address.
- R6: A group address at 2^GRP_W-1 wraps to 0 on its next transfer.
- R7: A start pulse at any time, including mid-slot, makes the cycle after the capturing edge the first cycle of slot 0, and sets all three group addresses to 0.
- R8: GRP_W+1 must not exceed SLOT_CYC. Any other setting is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Field-boundary sync; restarts the schedule and clears the group addresses |
| addr_bit | output | 1 | Serial group-address bit |
| addr_stb | output | 1 | Shift strobe qualifying addr_bit |
| xfer_stb | output | 1 | One-cycle transfer command |
| xfer_kind | output | 2 | Transfer kind of the current slot: 0 read fast, 1 read slow, 2 write |
| slot_idx | output | 2 | Index of the current slot within the main cycle |

## Verification
The assertions assume that start is a synchronous pulse of one or more cycles and that reset is applied before the first start. The slot and counter checks ignore any cycle in which start is high, because start overrides both. The stimulus raises start for exactly one cycle, away from the clock edge. It does so once from idle and once mid-slot, at a cycle chosen not to fall on a slot boundary. It then lets the schedule run long enough for the fast port to wrap twice and the slow ports to wrap once.

// File: rtl/ifx_seq_pkg.sv
package ifx_seq_pkg;
   localparam int NUM_SLOTS = 4;
   localparam int NUM_PORTS = 3;

   typedef enum logic [1:0] {
      XK_RD_FAST = 2'd0,
      XK_RD_SLOW = 2'd1,
      XK_WR      = 2'd2
   } xfer_kind_e;

   // fixed main-cycle pattern: fast read twice, slow read and write once
   function automatic xfer_kind_e kind_of_slot(input logic [1:0] s);
      case (s)
         2'd1:    return XK_RD_SLOW;
         2'd3:    return XK_WR;
         default: return XK_RD_FAST;
      endcase
   endfunction
endpackage

// File: rtl/ifx_slot_timer.sv
module ifx_slot_timer #(
   parameter int SLOT_CYC = 16,
   localparam int CYC_W = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             running,
   output logic [CYC_W-1:0] cyc,
   output logic [1:0]       slot,
   output logic             last_cyc
);
   assign last_cyc = running && (cyc == CYC_W'(SLOT_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cyc     <= '0;
         slot    <= '0;
      end else if (start) begin
         running <= 1'b1;
         cyc     <= '0;
         slot    <= '0;
      end else if (running) begin
         if (last_cyc) begin
            cyc  <= '0;
            slot <= slot + 2'd1;
         end else begin
            cyc <= cyc + CYC_W'(1);
         end
      end
   end

   // R7
   restart_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (running && cyc == '0 && slot == 2'd0));

   // R2
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_cyc && !start) |=> (slot == $past(slot) + 2'd1 && cyc == '0));
endmodule

// File: rtl/ifx_grp_counters.sv
module ifx_grp_counters #(
   parameter int GRP_W = 6,
   parameter int PORTS = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic [PORTS-1:0]           inc,
   output logic [PORTS-1:0][GRP_W-1:0] grp
);
   for (genvar p = 0; p < PORTS; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      grp[p] <= '0;
         else if (clr)    grp[p] <= '0;
         else if (inc[p]) grp[p] <= grp[p] + GRP_W'(1);
      end

      // R5
      grp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && !inc[p]) |=> $stable(grp[p]));

      // R6
      grp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && inc[p] && grp[p] == {GRP_W{1'b1}}) |=> (grp[p] == '0));
   end
endmodule

// File: rtl/ifx_addr_serializer.sv
module ifx_addr_serializer #(
   parameter int GRP_W     = 6,
   parameter int CYC_W     = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             running,
   input  logic [CYC_W-1:0] cyc,
   input  logic [GRP_W-1:0] grp_sel,
   output logic             sa_bit,
   output logic             sa_stb
);
   logic [CYC_W-1:0] pos;

   if (MSB_FIRST) begin : g_msb
      assign pos = CYC_W'(GRP_W - 1) - cyc;
   end else begin : g_lsb
      assign pos = cyc;
   end

   assign sa_stb = running && (cyc < CYC_W'(GRP_W));

   always_comb begin
      sa_bit = 1'b0;
      for (int i = 0; i < GRP_W; i++) begin
         if (sa_stb && pos == CYC_W'(i)) sa_bit = grp_sel[i];
      end
   end
endmodule

// File: rtl/ifx_transfer_seq.sv
module ifx_transfer_seq
   import ifx_seq_pkg::*;
#(
   parameter int GRP_W     = 6,
   parameter int SLOT_CYC  = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   output logic       addr_bit,
   output logic       addr_stb,
   output logic       xfer_stb,
   output logic [1:0] xfer_kind,
   output logic [1:0] slot_idx
);
   localparam int CYC_W = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;

   // R8
   if (GRP_W < 1 || GRP_W + 1 > SLOT_CYC) begin : g_shift_fit_chk
      $error("address shift of %0d bits does not fit a slot of %0d cycles", GRP_W, SLOT_CYC);
   end

   logic                             running;
   logic [CYC_W-1:0]                 cyc;
   logic [1:0]                       slot;
   logic                             last_cyc;
   xfer_kind_e                       kind;
   logic [NUM_PORTS-1:0]             inc;
   logic [NUM_PORTS-1:0][GRP_W-1:0]  grp;
   logic [GRP_W-1:0]                 grp_sel;

   ifx_slot_timer #(.SLOT_CYC(SLOT_CYC)) timer_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .running(running), .cyc(cyc), .slot(slot), .last_cyc(last_cyc)
   );

   assign kind      = kind_of_slot(slot);
   assign xfer_kind = kind;
   assign slot_idx  = slot;
   assign xfer_stb  = last_cyc;

   always_comb begin
      inc = '0;
      if (last_cyc) inc[kind] = 1'b1;
      grp_sel = grp[kind];
   end

   ifx_grp_counters #(.GRP_W(GRP_W), .PORTS(NUM_PORTS)) cnt_i (
      .clk(clk), .rst_n(rst_n), .clr(start), .inc(inc), .grp(grp)
   );

   ifx_addr_serializer #(.GRP_W(GRP_W), .CYC_W(CYC_W), .MSB_FIRST(MSB_FIRST)) ser_i (
      .running(running), .cyc(cyc), .grp_sel(grp_sel),
      .sa_bit(addr_bit), .sa_stb(addr_stb)
   );

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!addr_stb && !xfer_stb));

   // R4
   xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_stb && !start) |=> !xfer_stb);

   // R4
   phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(addr_stb && xfer_stb));

   // R3
   shift_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_stb && !start) |=> addr_stb);
endmodule

// File: tb/ifx_transfer_seq_tb_top.sv
module ifx_transfer_seq_tb_top;
   localparam int W = 6;
   localparam int S = 16;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, start;
   logic addr_bit, addr_stb, xfer_stb;
   logic [1:0] xfer_kind, slot_idx;

   ifx_transfer_seq #(.GRP_W(W), .SLOT_CYC(S), .MSB_FIRST(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .addr_bit(addr_bit), .addr_stb(addr_stb), .xfer_stb(xfer_stb),
      .xfer_kind(xfer_kind), .slot_idx(slot_idx)
   );

   typedef struct packed {
      logic [1:0]   kind;
      logic [W-1:0] addr;
   } item_t;

   item_t exp_q[$];
   int checks = 0;
   int errors = 0;
   int popped = 0;
   bit active = 1'b0;
   bit done = 1'b0;
   int t = 0;
   logic [W-1:0] shreg = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // driver side: expected transfers of n main cycles from a fresh start
   task automatic push_cycles(input int n);
      int a = 0, b = 0, c = 0;
      exp_q.delete();
      for (int m = 0; m < n; m++) begin
         exp_q.push_back(item_t'{2'd0, W'(a)}); a++;
         exp_q.push_back(item_t'{2'd1, W'(b)}); b++;
         exp_q.push_back(item_t'{2'd0, W'(a)}); a++;
         exp_q.push_back(item_t'{2'd2, W'(c)}); c++;
      end
   endtask

   task automatic do_start(input int n);
      @(posedge clk); #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      push_cycles(n);
      popped = 0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (!active) begin
            chk(!addr_stb && !xfer_stb, "R1", "strobes idle", {addr_stb, xfer_stb}, 0);
            chk(slot_idx == 2'd0, "R1", "slot idle", slot_idx, 0);
         end else begin
            chk(addr_stb == ((t % S) < W), "R3", "addr_stb phase", addr_stb, int'((t % S) < W));
            chk(xfer_stb == ((t % S) == S - 1), "R4", "xfer_stb phase", xfer_stb, int'((t % S) == S - 1));
            chk(slot_idx == 2'((t / S) % 4), "R2", "slot_idx", slot_idx, (t / S) % 4);
            chk(!(addr_stb && xfer_stb), "R4", "strobe overlap", 1, 0);
            if (addr_stb) shreg = {shreg[W-2:0], addr_bit};
            if (xfer_stb) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R2", "unexpected transfer", 1, 0);
               end else begin
                  item_t it;
                  it = exp_q.pop_front();
                  popped++;
                  chk(xfer_kind == it.kind, "R2", "xfer_kind", xfer_kind, it.kind);
                  if (it.addr == '0)
                     chk(shreg == it.addr, "R6 R7", "group address", shreg, it.addr);
                  else
                     chk(shreg == it.addr, "R5", "group address", shreg, it.addr);
               end
            end
         end
         if (start) begin
            active = 1'b1;
            t = 0;
            shreg = '0;
         end else if (active) begin
            t++;
         end
      end
   end

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;
      repeat (20) @(posedge clk);
      // first sync from idle
      do_start(80);
      repeat (3 * 4 * S + 21) @(posedge clk);
      // R7: mid-slot restart clears addresses and realigns slots
      do_start(80);
      repeat (70 * 4 * S) @(posedge clk);
      #3;
      chk(popped == 280, "R5", "transfers after restart", popped, 280);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule